// File: doc/BRIEF.md
# Byte-Wide Erasable ROM Mode Controller

This block is the synchronous control logic of a byte-wide, erasable, one-time-writable read-only memory, placed around a small storage array. Each clock edge samples three active-low controls: chip select, output gate and write strobe. It also samples two flags. One says the write supply is present. The other says address bit 9 carries its elevated identification voltage. From these the block picks one mode: standby, output off, read, identifier read, write, write check, or hold. The result goes to a registered byte output and a drive flag. A drive flag of 0 means the pins are high-impedance.

The array leaves reset, and every erase, with all bits at one. A write can only turn ones into zeros, so the stored byte becomes the old byte ANDed with the written byte. The `erase_req` input stands in for ultraviolet exposure and restores the whole array in one cycle. Identifier read returns one of two fixed codes, each with odd parity. Host software uses them to recognise the part.

All pins are plain, level-sampled controls with no valid/ready handshake. The part is a memory device whose bus timing is set by its chip-select and output-gate pins, so there is no stream to throttle and no back-pressure.

Top module: `eprom_ctl`

## Requirements
- R1: While `rst_n` is low, `dout_en` is 0 and `dout` is 00h. Every array byte is FFh after reset, including bytes written before the reset.
- R2: With `cs_n`=0, `og_n`=0, `wsup`=0 and `a9_hv`=0, the edge after the inputs are applied gives `dout_en`=1 and `dout` equal to the byte stored at `addr`.
- R3: With `cs_n`=1, the following edge gives `dout_en`=0 and `dout`=00h, whatever `og_n`, `a9_hv` and `wsup` are. No byte is written, even with `wsup`=1 and `wstb_n`=0.
- R4: With `cs_n`=0, `og_n`=1 and `wsup`=0, the following edge gives `dout_en`=0 and `dout`=00h.
- R5: With `wsup`=1, `cs_n`=0, `wstb_n`=0 and `og_n`=1, the byte at `addr` becomes its old value AND `din`, and `dout_en` goes to 0. A written 1 never sets a stored 0.
- R6: With `wsup`=1, `cs_n`=0, `og_n`=0 and `wstb_n`=1, the following edge drives the stored byte at `addr` with `dout_en`=1, and `a9_hv` is ignored.
- R7: With `wsup`=0, `cs_n`=0, `og_n`=0 and `a9_hv`=1, the output is an identifier.
  - If `addr`[ADDR_W-1:1] is zero, `addr`[0]=0 gives D5h and `addr`[0]=1 gives 0Eh.
  - If any of those upper bits is nonzero, the output is FFh.
- R8: Both identifier bytes have odd parity over all 8 bits, and bit 7 is the parity bit.
- R9: `erase_req`=1 sets every array byte to FFh at that edge, and it wins over a write in the same cycle.
- R10: A write strobe with `wsup`=0 is ignored: the array is unchanged.
- R11: With `wsup`=1, `cs_n`=0, `og_n`=0 and `wstb_n`=0 at once, nothing is written and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| og_n | input | 1 | Output gate, active low |
| wstb_n | input | 1 | Write strobe, active low |
| wsup | input | 1 | Write supply present flag |
| a9_hv | input | 1 | Identification voltage on address bit 9 |
| erase_req | input | 1 | Whole-array erase to FFh |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to write |
| dout | output | 8 | Output byte, 00h when not driven |
| dout_en | output | 1 | Output drive flag, 0 means high-impedance |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and is held for the whole cycle. They also assume that `addr` during a write names the byte the write-check properties then inspect. The bench changes all inputs only on the falling edge and never leaves a pin undriven. It keeps erase cycles away from read cycles, so that each check compares a settled array against a value worked out from the rules above.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUT_OFF,
    M_READ,
    M_IDENT,
    M_WRITE,
    M_CHECK,
    M_HOLD
  } mode_e;

  localparam logic [6:0] MFR_LOW7 = 7'h55;
  localparam logic [6:0] DEV_LOW7 = 7'h0E;

  function automatic logic [7:0] odd_byte(input logic [6:0] low7);
    return {~^low7, low7};
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  cs_n,
  input  logic  og_n,
  input  logic  wstb_n,
  input  logic  wsup,
  input  logic  a9_hv,
  output mode_e mode,
  output logic  wr_en,
  output logic  drive
);

  always_comb begin
    if (cs_n) begin
      mode = M_STANDBY;
    end else if (wsup) begin
      unique case ({og_n, wstb_n})
        2'b10:   mode = M_WRITE;
        2'b01:   mode = M_CHECK;
        default: mode = M_HOLD;
      endcase
    end else if (og_n) begin
      mode = M_OUT_OFF;
    end else if (a9_hv) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end

  assign wr_en = (mode == M_WRITE);
  assign drive = (mode == M_READ) || (mode == M_IDENT) || (mode == M_CHECK);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[addr] <= mem[addr] & wdata;
    end
  end

  assign rdata = mem[addr];

  // a write may only clear bits
  p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> ((mem[$past(addr)] & ~$past(wdata)) == '0)
      && ((mem[$past(addr)] & ~$past(rdata)) == '0));

  p_erase_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (mem[0] == '1) && (mem[DEPTH-1] == '1));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !erase) |=> (mem[$past(addr)] == $past(rdata)));

endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        id_byte
);

  logic sel_ok;

  assign sel_ok  = (addr[ADDR_W-1:1] == '0);
  assign id_byte = !sel_ok ? 8'hFF :
                   addr[0] ? odd_byte(DEV_LOW7) : odd_byte(MFR_LOW7);

  always_comb begin
    if (sel_ok) begin
      p_id_odd_r8: assert (^id_byte == 1'b1);
    end
  end

endmodule

// File: rtl/eprom_ctl.sv
module eprom_ctl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              og_n,
  input  logic              wstb_n,
  input  logic              wsup,
  input  logic              a9_hv,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  localparam int DATA_W = 8;

  mode_e             mode;
  logic              wr_en;
  logic              drive;
  logic [DATA_W-1:0] cell_q;
  logic [DATA_W-1:0] id_q;
  logic [DATA_W-1:0] next_byte;

  eprom_mode_dec u_dec (
    .cs_n   (cs_n),
    .og_n   (og_n),
    .wstb_n (wstb_n),
    .wsup   (wsup),
    .a9_hv  (a9_hv),
    .mode   (mode),
    .wr_en  (wr_en),
    .drive  (drive)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (erase_req),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (din),
    .rdata (cell_q)
  );

  eprom_id_rom #(.ADDR_W(ADDR_W)) u_id (
    .addr    (addr),
    .id_byte (id_q)
  );

  always_comb begin
    if (!drive)              next_byte = '0;
    else if (mode == M_IDENT) next_byte = id_q;
    else                     next_byte = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= next_byte;
      dout_en <= drive;
    end
  end

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !og_n && !wsup && !a9_hv) |=> dout_en && (dout == $past(cell_q)));

  p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_en && (dout == '0));

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && og_n && !wsup) |=> !dout_en);

  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && og_n && !wstb_n && wsup) |=> !dout_en);

  p_check_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !og_n && wstb_n && wsup) |=> dout_en && (dout == $past(cell_q)));

  p_both_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !og_n && !wstb_n && wsup) |=> !dout_en);

endmodule

// File: tb/sim_eprom_ctl.sv
module sim_eprom_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NVEC = 26;

  // fields: {cs_n,og_n,wstb_n,wsup,a9_hv,erase}, addr, din, exp_en, exp_dout, req
  localparam logic [32:0] VEC [NVEC] = '{
    {6'b001000, 6'd5,  8'h00, 1'b1, 8'hFF, 4'd2},  // R2 erased read
    {6'b010100, 6'd5,  8'hA5, 1'b0, 8'h00, 4'd5},  // R5 write
    {6'b001100, 6'd5,  8'h00, 1'b1, 8'hA5, 4'd6},  // R6 check
    {6'b010100, 6'd5,  8'h3C, 1'b0, 8'h00, 4'd5},  // R5 second write
    {6'b001000, 6'd5,  8'h00, 1'b1, 8'h24, 4'd5},  // R5 AND result
    {6'b010100, 6'd5,  8'hFF, 1'b0, 8'h00, 4'd5},  // R5 ones written
    {6'b001100, 6'd5,  8'h00, 1'b1, 8'h24, 4'd5},  // R5 zeros kept
    {6'b101000, 6'd5,  8'h00, 1'b0, 8'h00, 4'd3},  // R3 standby
    {6'b110100, 6'd5,  8'h00, 1'b0, 8'h00, 4'd3},  // R3 inhibit
    {6'b001000, 6'd5,  8'h00, 1'b1, 8'h24, 4'd3},  // R3 nothing written
    {6'b011000, 6'd5,  8'h00, 1'b0, 8'h00, 4'd4},  // R4 gate off
    {6'b010000, 6'd7,  8'h00, 1'b0, 8'h00, 4'd10}, // R10 strobe without supply
    {6'b001000, 6'd7,  8'h00, 1'b1, 8'hFF, 4'd10}, // R10 unchanged
    {6'b001010, 6'd0,  8'h00, 1'b1, 8'hD5, 4'd7},  // R7 maker code
    {6'b001010, 6'd1,  8'h00, 1'b1, 8'h0E, 4'd7},  // R7 part code
    {6'b001010, 6'd2,  8'h00, 1'b1, 8'hFF, 4'd7},  // R7 upper bit set
    {6'b001010, 6'd3,  8'h00, 1'b1, 8'hFF, 4'd7},  // R7 upper bit set
    {6'b000100, 6'd7,  8'h00, 1'b0, 8'h00, 4'd11}, // R11 both low
    {6'b001000, 6'd7,  8'h00, 1'b1, 8'hFF, 4'd11}, // R11 no write
    {6'b010100, 6'd7,  8'h81, 1'b0, 8'h00, 4'd5},  // R5 write
    {6'b001110, 6'd7,  8'h00, 1'b1, 8'h81, 4'd6},  // R6 check ignores a9
    {6'b010100, 6'd63, 8'h12, 1'b0, 8'h00, 4'd5},  // R5 top address
    {6'b010101, 6'd7,  8'h00, 1'b0, 8'h00, 4'd9},  // R9 erase with write
    {6'b001000, 6'd7,  8'h00, 1'b1, 8'hFF, 4'd9},  // R9
    {6'b001000, 6'd5,  8'h00, 1'b1, 8'hFF, 4'd9},  // R9
    {6'b001000, 6'd63, 8'h00, 1'b1, 8'hFF, 4'd9}   // R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, og_n = 1'b1, wstb_n = 1'b1;
  logic          wsup = 1'b0, a9_hv = 1'b0, erase_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eprom_ctl #(.ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .og_n      (og_n),
    .wstb_n    (wstb_n),
    .wsup      (wsup),
    .a9_hv     (a9_hv),
    .erase_req (erase_req),
    .addr      (addr),
    .din       (din),
    .dout      (dout),
    .dout_en   (dout_en)
  );

  task automatic chk(input int req, input logic e_en, input logic [7:0] e_d);
    n_chk++;
    if (dout_en !== e_en || dout !== e_d) begin
      n_fail++;
      $display("FAIL R%0d: en=%b dout=%h expected en=%b dout=%h",
               req, dout_en, dout, e_en, e_d);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic [AW-1:0] a, input logic [7:0] d);
    {cs_n, og_n, wstb_n, wsup, a9_hv, erase_req} = c;
    addr = a;
    din  = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(1, 1'b0, 8'h00);  // R1 outputs idle in reset
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][32:27], VEC[i][26:21], VEC[i][20:13]);
      chk(int'(VEC[i][3:0]), VEC[i][12], VEC[i][11:4]);
    end

    // R3: standby with gate low and identifier flag set
    drive(6'b101010, 6'd0, 8'h00);
    chk(3, 1'b0, 8'h00);

    // R8: parity of both identifier bytes seen on the pins
    for (int k = 0; k < 2; k++) begin
      drive(6'b001010, AW'(k), 8'h00);
      n_chk++;
      if (^dout !== 1'b1 || dout[7] !== ~^dout[6:0]) begin
        n_fail++;
        $display("FAIL R8: dout=%h parity=%b expected parity=1", dout, ^dout);
      end
    end

    // R1: a reset in mid-run restores the array
    drive(6'b010100, 6'd9, 8'h00);
    drive(6'b001100, 6'd9, 8'h00);
    chk(5, 1'b1, 8'h00);
    rst_n = 1'b0;
    #1;
    chk(1, 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(6'b001000, 6'd9, 8'h00);
    chk(1, 1'b1, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule